// File: doc/BRIEF.md
# Lane-Configurable Pixel Frame Serializer

This block takes one parallel pixel word per pixel period and sends it out serially. The word carries 24 colour bits plus vertical sync, horizontal sync and data enable. Each word becomes a 30-bit frame: the 27 payload bits, then an odd-parity bit, then two reserved zero bits. The frame leaves the block on one, two or three serial lanes. A two-bit link select picks how many lanes are used, so each lane carries 30, 15 or 10 bits per frame.

Everything runs on one high-speed bit clock, which the caller supplies at the matching multiple of the pixel rate. The pixel clock arrives as an ordinary input and is sampled on the bit clock. A polarity input decides whether its rising or its falling transition captures the word. A swap input reverses the 24-bit colour bus, which gives more freedom in board routing. The captured word waits in a holding register and moves into the shift register at the next frame boundary. The block also drives a recreated pixel-rate clock and one output enable per lane, which stands in for a high-impedance driver.

Top module: `lane_frame_serializer`

## Requirements
- R1: Frame bits are sent first to last in this order: R7..R0, G7..G0, B7..B0, VS, HS, DE, parity, then two reserved bits that are always 0.
- R2: The parity bit is 1 when the 27 payload bits (colour bits, VS, HS, DE) hold an even number of ones, and 0 otherwise. The reserved bits are not counted.
- R3: link_sel=2'b00 sends all 30 bits on lane 0. 2'b01 sends 15 bits each on lanes 0 and 1. 2'b10 sends 10 bits each on lanes 0, 1 and 2. In the multi-lane modes, lane k carries frame positions k*S to k*S+S-1, where S is the per-lane bit count.
- R4: A lane the current mode does not use has lane_oe low and lane_d at 0. link_sel=2'b11 disables every lane and holds pix_clk_out at 0.
- R5: In an active mode, pix_clk_out is high for the first floor(S/2) bit cycles of each frame and low for the rest. It rises in the same cycle that the frame's first bit appears on the lanes.
- R6: With swap=0, pix_data[23:16]=R[7:0], pix_data[15:8]=G[7:0] and pix_data[7:0]=B[7:0]. With swap=1 the bus is bit-reversed: pix_data[23:16]=B0..B7, pix_data[15:8]=G0..G7 and pix_data[7:0]=R0..R7.
- R7: With cpol=0 the word is captured on a rising transition of pix_clk, as seen by the bit clock. With cpol=1 it is captured on a falling transition. The other transition captures nothing.
- R8: A captured word and a new link_sel value take effect only at the next frame boundary. A capture or a mode change in the middle of a frame leaves the frame in flight unchanged.
- R9: During reset and until the first frame boundary, all lanes are disabled, lane_d is 0 and pix_clk_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | High-speed bit clock, a multiple of the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_clk | input | 1 | Pixel clock, sampled on bit_clk |
| cpol | input | 1 | Capture edge: 0 rising, 1 falling |
| swap | input | 1 | Reverses the colour bus order when 1 |
| link_sel | input | 2 | Lane mode: 00 one, 01 two, 10 three, 11 off |
| pix_data | input | 24 | Parallel colour word |
| vsync | input | 1 | Vertical sync bit |
| hsync | input | 1 | Horizontal sync bit |
| den | input | 1 | Data enable bit |
| lane_d | output | 3 | Serial data, one bit per lane |
| lane_oe | output | 3 | Per-lane output enable, low means high impedance |
| pix_clk_out | output | 1 | Recreated pixel-rate clock |

## Verification
The bench builds the block with its default 24-bit colour width, which gives a 30-bit frame and per-lane slices of 30, 15 and 10 bits. With these values all three slicing patterns, the odd-length 15-bit clock duty and the reserved link code are reachable in short runs. Random words, swap settings, capture polarities and modes are mixed with directed cases:
- all-zero and all-one payloads, for the two parity extremes;
- edges of the wrong polarity;
- a capture and a mode change made in the middle of a frame.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    LNK_ONE   = 2'b00,
    LNK_TWO   = 2'b01,
    LNK_THREE = 2'b10,
    LNK_OFF   = 2'b11
  } link_mode_e;

  // Number of lanes a mode drives.
  function automatic int unsigned lane_count(input link_mode_e m);
    case (m)
      LNK_ONE:   return 1;
      LNK_TWO:   return 2;
      LNK_THREE: return 3;
      default:   return 0;
    endcase
  endfunction

  // Bits per lane per frame; the disabled mode keeps the shortest period.
  function automatic int unsigned slice_len(input link_mode_e m, input int unsigned frame_w);
    if (m == LNK_OFF) return frame_w / 3;
    return frame_w / lane_count(m);
  endfunction

endpackage

// File: rtl/lfs_capture.sv
module lfs_capture
  import lfs_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_clk,
  input  logic                 cpol,
  input  logic                 swap,
  input  logic [PIX_W-1:0]     pix_data,
  input  logic                 vsync,
  input  logic                 hsync,
  input  logic                 den,
  output logic [PIX_W+5:0]     held_frame,
  output logic                 cap_strobe
);
  localparam int FRAME_W = PIX_W + 6;

  logic             pix_q;
  logic [PIX_W-1:0] reversed;
  logic [PIX_W-1:0] colour;
  logic [PIX_W+2:0] payload;
  logic             parity_bit;
  logic [FRAME_W-1:0] frame_d;

  // Bit-reversed view of the colour bus.
  for (genvar i = 0; i < PIX_W; i++) begin : g_rev
    assign reversed[i] = pix_data[PIX_W-1-i];
  end

  assign colour     = swap ? reversed : pix_data;
  assign payload    = {colour, vsync, hsync, den};
  assign parity_bit = ~^payload;
  assign frame_d    = {payload, parity_bit, 2'b00};

  assign cap_strobe = cpol ? (pix_q & ~pix_clk) : (~pix_q & pix_clk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q      <= 1'b0;
      held_frame <= '0;
    end else begin
      pix_q <= pix_clk;
      if (cap_strobe) held_frame <= frame_d;
    end
  end

endmodule

// File: rtl/lfs_timer.sv
module lfs_timer
  import lfs_pkg::*;
#(
  parameter int FRAME_W = 30
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  link_sel,
  output link_mode_e                  mode_q,
  output logic [$clog2(FRAME_W)-1:0]  bit_cnt,
  output logic                        frame_load,
  output logic                        clk_recreated
);
  localparam int CW = $clog2(FRAME_W);

  int unsigned   slice;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] half_idx;

  always_comb begin
    slice    = slice_len(mode_q, FRAME_W);
    last_idx = CW'(slice - 1);
    half_idx = CW'(slice / 2);
  end

  assign frame_load    = (bit_cnt == last_idx);
  assign clk_recreated = (mode_q != LNK_OFF) && (bit_cnt < half_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      mode_q  <= LNK_OFF;
    end else if (frame_load) begin
      bit_cnt <= '0;
      mode_q  <= link_mode_e'(link_sel);
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lfs_lanes.sv
module lfs_lanes
  import lfs_pkg::*;
#(
  parameter int FRAME_W = 30,
  parameter int LANES   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  link_mode_e         mode_q,
  input  logic               frame_load,
  input  logic [FRAME_W-1:0] held_frame,
  output logic [FRAME_W-1:0] shift_q,
  output logic [LANES-1:0]   lane_d,
  output logic [LANES-1:0]   lane_oe
);

  always_ff @(posedge clk) begin
    if (!rst_n)          shift_q <= '0;
    else if (frame_load) shift_q <= held_frame;
    else                 shift_q <= shift_q << 1;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int TAP1 = FRAME_W - 1;
    localparam int TAP2 = (k < 2) ? FRAME_W - 1 - k * (FRAME_W / 2) : 0;
    localparam int TAP3 = FRAME_W - 1 - k * (FRAME_W / 3);

    logic tap_bit;

    always_comb begin
      case (mode_q)
        LNK_ONE:   tap_bit = shift_q[TAP1];
        LNK_TWO:   tap_bit = shift_q[TAP2];
        LNK_THREE: tap_bit = shift_q[TAP3];
        default:   tap_bit = 1'b0;
      endcase
    end

    assign lane_oe[k] = (k < lane_count(mode_q));
    assign lane_d[k]  = lane_oe[k] & tap_bit;
  end

endmodule

// File: rtl/lane_frame_serializer.sv
module lane_frame_serializer
  import lfs_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             pix_clk,
  input  logic             cpol,
  input  logic             swap,
  input  logic [1:0]       link_sel,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             vsync,
  input  logic             hsync,
  input  logic             den,
  output logic [2:0]       lane_d,
  output logic [2:0]       lane_oe,
  output logic             pix_clk_out
);
  localparam int FRAME_W = PIX_W + 6;
  localparam int LANES   = 3;
  localparam int CW      = $clog2(FRAME_W);

  // Named internal events, visible to the bound checker.
  logic [FRAME_W-1:0] held_frame;
  logic               cap_strobe;
  logic [FRAME_W-1:0] frame_shift;
  logic               frame_load;
  logic [CW-1:0]      bit_cnt;
  link_mode_e         mode_now;

  lfs_capture #(.PIX_W(PIX_W)) u_capture (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .pix_clk    (pix_clk),
    .cpol       (cpol),
    .swap       (swap),
    .pix_data   (pix_data),
    .vsync      (vsync),
    .hsync      (hsync),
    .den        (den),
    .held_frame (held_frame),
    .cap_strobe (cap_strobe)
  );

  lfs_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk           (bit_clk),
    .rst_n         (rst_n),
    .link_sel      (link_sel),
    .mode_q        (mode_now),
    .bit_cnt       (bit_cnt),
    .frame_load    (frame_load),
    .clk_recreated (pix_clk_out)
  );

  lfs_lanes #(.FRAME_W(FRAME_W), .LANES(LANES)) u_lanes (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .mode_q     (mode_now),
    .frame_load (frame_load),
    .held_frame (held_frame),
    .shift_q    (frame_shift),
    .lane_d     (lane_d),
    .lane_oe    (lane_oe)
  );

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
  parameter int FRAME_W = 30
) (
  input logic               bit_clk,
  input logic               rst_n,
  input logic               frame_load,
  input logic [FRAME_W-1:0] frame_shift,
  input logic [1:0]         mode_bits,
  input logic [2:0]         lane_d,
  input logic [2:0]         lane_oe,
  input logic               pix_clk_out
);

  p_reserved_zero_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_load |=> (frame_shift[1:0] == 2'b00));

  p_parity_odd_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_load |=> (($countones(frame_shift[FRAME_W-1:2]) % 2) == 1));

  p_lane_order_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (lane_oe == 3'b000) || (lane_oe == 3'b001) || (lane_oe == 3'b011) || (lane_oe == 3'b111));

  p_idle_lane_low_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (lane_d & ~lane_oe) == 3'b000);

  p_off_no_clock_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (lane_oe == 3'b000) |-> !pix_clk_out);

  p_clock_at_frame_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_load |=> ((lane_oe == 3'b000) || pix_clk_out));

  p_mode_at_boundary_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !frame_load |=> $stable(mode_bits));

endmodule

bind lane_frame_serializer lfs_checker #(.FRAME_W(FRAME_W)) u_lfs_checker (
  .bit_clk     (bit_clk),
  .rst_n       (rst_n),
  .frame_load  (frame_load),
  .frame_shift (frame_shift),
  .mode_bits   (mode_now),
  .lane_d      (lane_d),
  .lane_oe     (lane_oe),
  .pix_clk_out (pix_clk_out)
);

// File: tb/lane_frame_serializer_bench.sv
`timescale 1ns/1ps
module lane_frame_serializer_bench;
  localparam int FW = 30;

  logic        bit_clk = 1'b0;
  logic        rst_n;
  logic        pix_clk;
  logic        cpol;
  logic        swap;
  logic [1:0]  link_sel;
  logic [23:0] pix_data;
  logic        vsync, hsync, den;
  logic [2:0]  lane_d;
  logic [2:0]  lane_oe;
  logic        pix_clk_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 bit_clk = ~bit_clk;

  lane_frame_serializer u_lane_frame_serializer (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .pix_clk     (pix_clk),
    .cpol        (cpol),
    .swap        (swap),
    .link_sel    (link_sel),
    .pix_data    (pix_data),
    .vsync       (vsync),
    .hsync       (hsync),
    .den         (den),
    .lane_d      (lane_d),
    .lane_oe     (lane_oe),
    .pix_clk_out (pix_clk_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected frame, first transmitted bit at index 0 (R1, R2, R6).
  function automatic logic [0:FW-1] exp_seq(input logic [23:0] pd, input logic sw,
                                            input logic v, input logic h, input logic e);
    logic [7:0] r, g, b;
    logic [0:FW-1] s;
    int ones;
    for (int k = 0; k < 8; k++) begin
      r[k] = sw ? pd[7-k]  : pd[16+k];
      g[k] = sw ? pd[15-k] : pd[8+k];
      b[k] = sw ? pd[23-k] : pd[k];
    end
    for (int i = 0; i < 8; i++) begin
      s[i]    = r[7-i];
      s[8+i]  = g[7-i];
      s[16+i] = b[7-i];
    end
    s[24] = v; s[25] = h; s[26] = e;
    ones = 0;
    for (int i = 0; i < 27; i++) ones += int'(s[i]);
    s[27] = ((ones % 2) == 0);
    s[28] = 1'b0;
    s[29] = 1'b0;
    return s;
  endfunction

  // Capture a word with the edge selected by cpol (R7).
  task automatic capture(input logic [23:0] pd, input logic v, input logic h, input logic e);
    pix_data = pd; vsync = v; hsync = h; den = e;
    @(negedge bit_clk);
    pix_clk = ~cpol;
    repeat (2) @(negedge bit_clk);
    pix_clk = cpol;
    @(negedge bit_clk);
  endtask

  // Collect one frame and compare against the expected lane slices (R1..R5, R8).
  task automatic collect(input logic [1:0] m, input logic [0:FW-1] es,
                         input bit poke, input logic [23:0] pd2, input logic [1:0] m2);
    int n, nl, highs, guard;
    logic prev;
    logic [0:FW-1] got [3];
    logic [0:FW-1] want [3];
    logic [2:0] oe_exp;
    bit oe_ok, idle_ok;
    if (m == 2'b11) begin
      idle_ok = 1'b1;
      for (int j = 0; j < 40; j++) begin
        @(negedge bit_clk);
        if (lane_oe != 3'b000 || lane_d != 3'b000 || pix_clk_out) idle_ok = 1'b0;
      end
      check(idle_ok, "R4 reserved code all off", {29'd0, lane_oe}, 32'd0);
      return;
    end
    n  = (m == 2'b00) ? 30 : (m == 2'b01) ? 15 : 10;
    nl = int'(m) + 1;
    oe_exp = (nl == 1) ? 3'b001 : (nl == 2) ? 3'b011 : 3'b111;
    guard = 0;
    prev  = pix_clk_out;
    @(negedge bit_clk);
    while (!(pix_clk_out && !prev) && guard < 100) begin
      prev = pix_clk_out;
      @(negedge bit_clk);
      guard++;
    end
    check(guard < 100, "R5 clock rise found", guard, 32'd0);
    highs = 0; oe_ok = 1'b1; idle_ok = 1'b1;
    for (int k = 0; k < 3; k++) begin
      got[k]  = '0;
      want[k] = '0;
    end
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge bit_clk);
      for (int k = 0; k < 3; k++) begin
        got[k][j] = lane_d[k];
        if (k < nl) want[k][j] = es[k*n+j];
      end
      if (pix_clk_out) highs++;
      if (lane_oe != oe_exp) oe_ok = 1'b0;
      for (int k = 0; k < 3; k++)
        if (k >= nl && lane_d[k] != 1'b0) idle_ok = 1'b0;
      if (poke && j == 2) begin
        pix_data = pd2;
        link_sel = m2;
        pix_clk  = ~cpol;
      end
      if (poke && j == 4) pix_clk = cpol;
    end
    for (int k = 0; k < 3; k++)
      check(got[k] == want[k], "R1 R3 lane slice", got[k][0:29] >> 2, want[k][0:29] >> 2);
    check(oe_ok, "R3 lane enables", {29'd0, lane_oe}, {29'd0, oe_exp});
    check(idle_ok, "R4 unused lanes low", {29'd0, lane_d}, 32'd0);
    check(highs == n / 2, "R5 clock duty", highs, n / 2);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge bit_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] a, b;
    logic [1:0]  m;
    logic        v, h, e;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; pix_clk = 1'b0; cpol = 1'b0; swap = 1'b0; link_sel = 2'b00;
    pix_data = '0; vsync = 0; hsync = 0; den = 0;
    repeat (5) @(negedge bit_clk);
    check(lane_oe == 3'b000 && lane_d == 3'b000 && !pix_clk_out, "R9 reset state",
          {28'd0, pix_clk_out, lane_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check(lane_oe == 3'b000 && lane_d == 3'b000 && !pix_clk_out, "R9 after reset",
          {28'd0, pix_clk_out, lane_oe}, 32'd0);

    // Parity extremes, one lane (R2)
    capture(24'h000000, 0, 0, 0);
    repeat (70) @(negedge bit_clk);
    collect(2'b00, exp_seq(24'h000000, 0, 0, 0, 0), 0, '0, 2'b00);
    capture(24'hFFFFFF, 1, 1, 1);
    repeat (70) @(negedge bit_clk);
    collect(2'b00, exp_seq(24'hFFFFFF, 0, 1, 1, 1), 0, '0, 2'b00);

    // Swap on a lopsided word, two lanes (R6)
    link_sel = 2'b01;
    for (int s = 0; s < 2; s++) begin
      swap = s[0];
      capture(24'h0000F1, 0, 1, 0);
      repeat (70) @(negedge bit_clk);
      collect(2'b01, exp_seq(24'h0000F1, s[0], 0, 1, 0), 0, '0, 2'b01);
    end
    swap = 1'b0;

    // Wrong edge ignored (R7): cpol=0, capture A, then falling edge with B
    link_sel = 2'b10;
    a = 24'hA5C30F; b = 24'h3C5AF0;
    capture(a, 1, 0, 1);
    pix_clk = 1'b1;
    repeat (2) @(negedge bit_clk);
    pix_data = b;
    repeat (2) @(negedge bit_clk);
    pix_clk = 1'b0;
    repeat (70) @(negedge bit_clk);
    collect(2'b10, exp_seq(a, 0, 1, 0, 1), 0, '0, 2'b10);

    // Falling-edge capture with cpol=1 (R7)
    cpol = 1'b1;
    @(negedge bit_clk);
    pix_clk = 1'b1;
    repeat (3) @(negedge bit_clk);
    capture(b, 0, 0, 1);
    repeat (70) @(negedge bit_clk);
    collect(2'b10, exp_seq(b, 0, 0, 0, 1), 0, '0, 2'b10);

    // Mid-frame capture and mode change leave the frame in flight alone (R8)
    collect(2'b10, exp_seq(b, 0, 0, 0, 1), 1, a, 2'b00);
    collect(2'b00, exp_seq(a, 0, 0, 0, 1), 0, '0, 2'b00);

    // Reserved link code (R4)
    link_sel = 2'b11;
    repeat (70) @(negedge bit_clk);
    collect(2'b11, '0, 0, '0, 2'b11);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      m = 2'($urandom_range(0, 3));
      a = 24'($urandom);
      v = 1'($urandom); h = 1'($urandom); e = 1'($urandom);
      swap = 1'($urandom);
      cpol = 1'($urandom);
      link_sel = m;
      @(negedge bit_clk);
      pix_clk = cpol;
      repeat (3) @(negedge bit_clk);
      capture(a, v, h, e);
      repeat (70) @(negedge bit_clk);
      collect(m, exp_seq(a, swap, v, h, e), 0, '0, m);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule